// File: doc/BRIEF.md
# Protection-Dependent Checksum Engine

This engine produces the 16-bit checksum of a programmable device's memory image. It fetches the image one word at a time through a request/accept read port. It always reads the two configuration words first. The protection flag inside the first configuration word then selects one of two summation paths.

When the flag is inactive, every program word from address zero up to a parameterised depth is summed. When the flag is active, program memory is skipped. The four identification words are read, and the low four bits of each are packed into a single 16-bit word. In both cases each configuration word is ANDed with its mask before it is added. The masks are caller inputs that mark the implemented bits.

A single `start_i` pulse launches a run. When the total is final, the engine raises `done_o` for one cycle. `sum_o` keeps the result until the next run begins.

Top module: `cpchk_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `done_o` and `rd_valid_o` are 0 and `sum_o` is 0.
- R2: After `start_i` is accepted, the first read request targets `CFG_BASE+7` (configuration word 1) and the second targets `CFG_BASE+8` (configuration word 2).
- R3: If bit `CP_BIT` of the raw configuration word 1 is 1 (protection off), the next requests cover addresses 0 to `PROG_WORDS-1` in ascending order. The result is the sum of those words plus both masked configuration words.
- R4: If bit `CP_BIT` of the raw configuration word 1 is 0 (protection on), no program address is requested. The next requests cover `CFG_BASE+0` to `CFG_BASE+3` in ascending order. The result is both masked configuration words plus the packed identification word.
- R5: The packed identification word is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, where id0 is the word at `CFG_BASE+0`. Bits above bit 3 of each identification word have no effect.
- R6: Configuration word 1 is ANDed bitwise with `cfg1_mask_i`, and configuration word 2 with `cfg2_mask_i`, before each is added. The protection decision uses the unmasked bit.
- R7: All additions are modulo 2^16, and carries out of bit 15 are dropped.
- R8: While `rd_valid_o` is 1 and `rd_ready_i` is 0, the request and its address hold, and nothing is accumulated.
- R9: `done_o` is high for exactly one cycle, the cycle after the final accepted read. `sum_o` then holds the result until the next accepted `start_i`.
- R10: `start_i` is ignored while a run is in progress or `done_o` is high.
- R11: `rd_valid_o` is 0 when idle and while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a checksum run (taken only when idle) |
| cfg1_mask_i | input | WORD_W | Implemented-bit mask for configuration word 1 |
| cfg2_mask_i | input | WORD_W | Implemented-bit mask for configuration word 2 |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ready_i | input | 1 | Memory accepts the request; `rd_data_i` is valid in the same cycle |
| rd_data_i | input | WORD_W | Read data for `rd_addr_o` |
| done_o | output | 1 | One-cycle pulse when the result is final |
| sum_o | output | SUM_W | Checksum result |

## Verification
The protection-off path runs against three program images: a position-dependent pattern with full masks, the same pattern with sparse masks under heavy stalling, and an all-ones image whose total wraps many times. Together these separate correct masking, ordering and modulo arithmetic from near misses. The protection-on path runs with two identification sets. One set has clean low nibbles and the other has its upper bits filled, which exposes wrong nibble order or leakage of high bits. The second set also uses a mask that clears the protection bit, to show that the path decision uses the raw bit. Random stalls and stray start pulses during every run check that the address sequence never skips, repeats or restarts.

// File: rtl/cpchk_pkg.sv
package cpchk_pkg;

    // Run phases of the engine.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CFG1 = 3'd1,
        PH_CFG2 = 3'd2,
        PH_PROG = 3'd3,
        PH_UID  = 3'd4,
        PH_DONE = 3'd5
    } phase_e;

    // Offsets inside the configuration space; the read order depends on them.
    localparam int unsigned UID_OFS  = 0;
    localparam int unsigned CFG1_OFS = 7;
    localparam int unsigned CFG2_OFS = 8;

    // Identification packing geometry.
    localparam int unsigned NUM_UID = 4;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned PACK_W  = NUM_UID * NIB_W;
    localparam int unsigned HOLD_W  = PACK_W - NIB_W;

    // Append one nibble below the nibbles already gathered.
    function automatic logic [PACK_W-1:0] pack_append(
        input logic [HOLD_W-1:0] held,
        input logic [NIB_W-1:0]  nib
    );
        return {held, nib};
    endfunction

    // True for phases that issue a read request.
    function automatic logic phase_reads(input phase_e ph);
        return (ph == PH_CFG1) || (ph == PH_CFG2) || (ph == PH_PROG) || (ph == PH_UID);
    endfunction

endpackage

// File: rtl/cpchk_seq.sv
module cpchk_seq
    import cpchk_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned PROG_WORDS = 4096,
    parameter int unsigned CFG_BASE   = 32'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_ready_i,
    input  logic              cp_bit_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output phase_e            phase_o,
    output logic              fire_o,
    output logic              last_o,
    output logic              clear_o,
    output logic              done_o
);
    localparam int unsigned CNT_W = (PROG_WORDS > 4) ? $clog2(PROG_WORDS) : 2;
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_WORDS - 1);
    localparam logic [CNT_W-1:0] UID_LAST  = CNT_W'(NUM_UID - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] idx_q;
    logic             cp_on_q;
    logic             idx_end;

    assign rd_valid_o = phase_reads(phase_q);
    assign fire_o     = rd_valid_o && rd_ready_i;
    assign clear_o    = (phase_q == PH_IDLE) && start_i;
    assign done_o     = (phase_q == PH_DONE);
    assign phase_o    = phase_q;

    always_comb begin
        idx_end = 1'b0;
        if (phase_q == PH_PROG) idx_end = (idx_q == PROG_LAST);
        if (phase_q == PH_UID)  idx_end = (idx_q == UID_LAST);
    end
    assign last_o = fire_o && idx_end;

    always_comb begin
        unique case (phase_q)
            PH_CFG1: rd_addr_o = ADDR_W'(CFG_BASE + CFG1_OFS);
            PH_CFG2: rd_addr_o = ADDR_W'(CFG_BASE + CFG2_OFS);
            PH_PROG: rd_addr_o = ADDR_W'(idx_q);
            PH_UID:  rd_addr_o = ADDR_W'(CFG_BASE + UID_OFS) + ADDR_W'(idx_q);
            default: rd_addr_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            cp_on_q <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start_i) phase_q <= PH_CFG1;
                PH_CFG1: if (fire_o) begin
                    cp_on_q <= ~cp_bit_i;
                    phase_q <= PH_CFG2;
                end
                PH_CFG2: if (fire_o) begin
                    idx_q   <= '0;
                    phase_q <= cp_on_q ? PH_UID : PH_PROG;
                end
                PH_PROG, PH_UID: if (fire_o) begin
                    if (idx_end) phase_q <= PH_DONE;
                    else         idx_q   <= idx_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cpchk_nibpack.sv
module cpchk_nibpack
    import cpchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [PACK_W-1:0] word_o
);
    logic [HOLD_W-1:0] held_q;

    // The completed word includes the nibble arriving in this cycle.
    assign word_o = pack_append(held_q, nib_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            held_q <= '0;
        end else if (shift_i) begin
            held_q <= word_o[HOLD_W-1:0];
        end
    end
endmodule

// File: rtl/cpchk_acc.sv
module cpchk_acc
    import cpchk_pkg::*;
#(
    parameter int unsigned WORD_W = 14,
    parameter int unsigned SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              fire_i,
    input  logic              last_i,
    input  phase_e            phase_i,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic [WORD_W-1:0] cfg1_mask_i,
    input  logic [WORD_W-1:0] cfg2_mask_i,
    input  logic [PACK_W-1:0] packed_i,
    output logic [SUM_W-1:0]  sum_o
);
    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] acc_q;

    always_comb begin
        unique case (phase_i)
            PH_CFG1: addend = SUM_W'(rd_data_i & cfg1_mask_i);
            PH_CFG2: addend = SUM_W'(rd_data_i & cfg2_mask_i);
            PH_PROG: addend = SUM_W'(rd_data_i);
            PH_UID:  addend = last_i ? SUM_W'(packed_i) : '0;
            default: addend = '0;
        endcase
    end

    // Width SUM_W makes the wrap implicit: carries past the top bit vanish.
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
        end else if (fire_i) begin
            acc_q <= acc_q + addend;
        end
    end

    assign sum_o = acc_q;
endmodule

// File: rtl/cpchk_engine.sv
module cpchk_engine
    import cpchk_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned WORD_W     = 14,
    parameter int unsigned SUM_W      = 16,
    parameter int unsigned PROG_WORDS = 4096,
    parameter int unsigned CFG_BASE   = 32'h2000,
    parameter int unsigned CP_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cfg1_mask_i,
    input  logic [WORD_W-1:0] cfg2_mask_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ready_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              done_o,
    output logic [SUM_W-1:0]  sum_o
);
    phase_e            phase;
    logic              fire;
    logic              last;
    logic              clear;
    logic [PACK_W-1:0] packed_word;

    cpchk_seq #(
        .ADDR_W     (ADDR_W),
        .PROG_WORDS (PROG_WORDS),
        .CFG_BASE   (CFG_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rd_ready_i (rd_ready_i),
        .cp_bit_i   (rd_data_i[CP_BIT]),
        .rd_valid_o (rd_valid_o),
        .rd_addr_o  (rd_addr_o),
        .phase_o    (phase),
        .fire_o     (fire),
        .last_o     (last),
        .clear_o    (clear),
        .done_o     (done_o)
    );

    cpchk_nibpack u_pack (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .shift_i (fire && (phase == PH_UID)),
        .nib_i   (rd_data_i[NIB_W-1:0]),
        .word_o  (packed_word)
    );

    cpchk_acc #(
        .WORD_W (WORD_W),
        .SUM_W  (SUM_W)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .fire_i      (fire),
        .last_i      (last),
        .phase_i     (phase),
        .rd_data_i   (rd_data_i),
        .cfg1_mask_i (cfg1_mask_i),
        .cfg2_mask_i (cfg2_mask_i),
        .packed_i    (packed_word),
        .sum_o       (sum_o)
    );
endmodule

// File: rtl/cpchk_sva.sv
module cpchk_sva #(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned SUM_W      = 16,
    parameter int unsigned PROG_WORDS = 4096,
    parameter int unsigned CFG_BASE   = 32'h2000
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              done_o,
    input logic [SUM_W-1:0]  sum_o
);
    // R1: outputs come out of reset quiet and cleared
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!done_o && !rd_valid_o && sum_o == '0));

    // R2: the first request of a run targets configuration word 1
    assert_first_read_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid_o) |-> (rd_addr_o == ADDR_W'(CFG_BASE + 7)));

    // R3/R4: every request falls in program memory or the configuration window
    assert_addr_window_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ((32'(rd_addr_o) < PROG_WORDS) ||
                        ((32'(rd_addr_o) >= CFG_BASE) && (32'(rd_addr_o) <= CFG_BASE + 8))));

    // R8: a stalled request holds and nothing is accumulated
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o) && $stable(sum_o)));

    // R9: done is a single-cycle pulse and the result stays put afterwards
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && $stable(sum_o)));

    // R11: no request while done is shown
    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_valid_o);
endmodule

bind cpchk_engine cpchk_sva #(
    .ADDR_W     (ADDR_W),
    .SUM_W      (SUM_W),
    .PROG_WORDS (PROG_WORDS),
    .CFG_BASE   (CFG_BASE)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_addr_o  (rd_addr_o),
    .done_o     (done_o),
    .sum_o      (sum_o)
);

// File: tb/cpchk_engine_test.sv
`timescale 1ns/1ps
module cpchk_engine_test;
    localparam int ADDR_W = 14;
    localparam int WORD_W = 14;
    localparam int SUM_W  = 16;
    localparam int PW     = 512;
    localparam int BASE   = 32'h2000;
    localparam int CPB    = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              rd_ready_i = 1'b0;
    logic [WORD_W-1:0] m1 = '0, m2 = '0;
    logic [WORD_W-1:0] rd_data_i;
    logic              rd_valid_o, done_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [SUM_W-1:0]  sum_o;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // memory model state
    logic [WORD_W-1:0] cfg1_v, cfg2_v;
    logic [WORD_W-1:0] uid_v [4];
    int                seed_v;
    bit                ones_v;

    always #2.5 clk = ~clk;

    cpchk_engine #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_W(SUM_W),
        .PROG_WORDS(PW), .CFG_BASE(BASE), .CP_BIT(CPB)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cfg1_mask_i(m1), .cfg2_mask_i(m2),
        .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
        .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .sum_o(sum_o)
    );

    function automatic logic [WORD_W-1:0] prog_word(int a, int s, bit ones);
        if (ones) return '1;
        return WORD_W'((a * 193 + s * 29 + (a >> 2)) ^ (s << 3));
    endfunction

    always_comb begin
        int a;
        a = int'(rd_addr_o);
        if (a == BASE + 7)                    rd_data_i = cfg1_v;
        else if (a == BASE + 8)               rd_data_i = cfg2_v;
        else if (a >= BASE && a <= BASE + 3)  rd_data_i = uid_v[a - BASE];
        else if (a < PW)                      rd_data_i = prog_word(a, seed_v, ones_v);
        else                                  rd_data_i = '0;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [WORD_W-1:0] c1, input logic [WORD_W-1:0] c2,
                            input logic [WORD_W-1:0] mk1, input logic [WORD_W-1:0] mk2,
                            input int seed, input int stall, input bit ones, input string tag);
        logic [ADDR_W-1:0] q[$];
        logic [SUM_W-1:0]  exp;
        bit   cp_on, prev_stall, prev_busy_start;
        string req;
        cfg1_v = c1; cfg2_v = c2; m1 = mk1; m2 = mk2; seed_v = seed; ones_v = ones;
        cp_on = (c1[CPB] == 1'b0);
        exp = SUM_W'(c1 & mk1) + SUM_W'(c2 & mk2);
        q.push_back(ADDR_W'(BASE + 7));
        q.push_back(ADDR_W'(BASE + 8));
        if (cp_on) begin
            exp = exp + {uid_v[0][3:0], uid_v[1][3:0], uid_v[2][3:0], uid_v[3][3:0]};
            for (int k = 0; k < 4; k++) q.push_back(ADDR_W'(BASE + k));
        end else begin
            for (int a = 0; a < PW; a++) begin
                exp = exp + SUM_W'(prog_word(a, seed, ones));
                q.push_back(ADDR_W'(a));
            end
        end
        @(negedge clk);
        start_i = 1'b1;
        rd_ready_i = 1'b0;
        prev_stall = 0;
        prev_busy_start = 0;
        while (q.size() > 0) begin
            @(negedge clk);
            // R2 for the configuration reads, R3/R4 for the path, R8 after a stall, R10 after a stray start
            if (prev_busy_start)       req = "R10";
            else if (prev_stall)       req = "R8";
            else if (32'(q[0]) == BASE + 7 || 32'(q[0]) == BASE + 8) req = "R2";
            else                       req = cp_on ? "R4" : "R3";
            check(rd_valid_o === 1'b1 && rd_addr_o === q[0], req, "read address",
                  {rd_valid_o, rd_addr_o}, {1'b1, q[0]});
            check(done_o === 1'b0, "R9", "done while busy", done_o, 0);
            rd_ready_i = ($urandom % 100) >= stall;
            start_i = (q.size() > 1) && (($urandom % 4) == 0);
            prev_stall = !rd_ready_i;
            prev_busy_start = start_i;
            @(posedge clk);
            if (rd_ready_i) void'(q.pop_front());
        end
        @(negedge clk);
        start_i = 1'b0;
        rd_ready_i = 1'b0;
        check(done_o === 1'b1, "R9", "done pulse", done_o, 1);
        check(sum_o === exp, tag, "checksum", sum_o, exp);
        check(rd_valid_o === 1'b0, "R11", "request during done", rd_valid_o, 0);
        @(negedge clk);
        check(done_o === 1'b0, "R9", "done width", done_o, 0);
        check(sum_o === exp, "R9", "held result", sum_o, exp);
        check(rd_valid_o === 1'b0, "R11", "request when idle", rd_valid_o, 0);
    endtask

    initial begin
        cfg1_v = '0; cfg2_v = '0; seed_v = 0; ones_v = 0;
        for (int k = 0; k < 4; k++) uid_v[k] = '0;
        repeat (3) @(negedge clk);
        // R1: the reset state is visible while reset is held
        check(done_o === 1'b0 && rd_valid_o === 1'b0 && sum_o === '0, "R1", "reset outputs",
              {done_o, rd_valid_o, sum_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o === 1'b0 && rd_valid_o === 1'b0 && sum_o === '0, "R1", "after reset",
              {done_o, rd_valid_o, sum_o}, 0);

        // protection off, full masks, no stalls
        run_case(14'h3FFF, 14'h1234, 14'h3FFF, 14'h3FFF, 1, 0, 0, "R3");
        // protection off, sparse masks, heavy stalls
        run_case(14'h2C5F, 14'h3A7E, 14'h2AE5, 14'h0103, 7, 40, 0, "R6");
        // protection off, all-ones image wraps the 16-bit total many times
        run_case(14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 3, 20, 1, "R7");
        // protection on, clean identification nibbles
        uid_v[0] = 14'h1235; uid_v[1] = 14'h0ACD; uid_v[2] = 14'h3FF7; uid_v[3] = 14'h0009;
        run_case(14'h3FBF, 14'h0A5C, 14'h3FFF, 14'h3FFF, 5, 0, 0, "R4");
        // protection on, upper bits filled, mask hides the protection bit
        uid_v[0] = 14'h3FF1; uid_v[1] = 14'h2AA2; uid_v[2] = 14'h1553; uid_v[3] = 14'h3FF4;
        run_case(14'h2B0E, 14'h1111, 14'h3FBF, 14'h0F0F, 9, 50, 0, "R5");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule